// File: doc/BRIEF.md
# Atomic CSR Read-Modify-Write Unit

This block carries out the three atomic control-register instructions of a processor pipeline: swap, bit-set and bit-clear. All three feed one masked-write core. The core reads the old register value, writes `(old & ~mask) | (value & mask)` on the same clock edge, and returns the old value. Swap uses the source operand as the value with a mask of all ones. Bit-set uses a value of all ones with the source operand as the mask. Bit-clear uses a value of zero with the source operand as the mask. When the instruction names register zero as its source, the pipeline drives `req_src_nz` low. For bit-set and bit-clear the mask is then forced to zero, so the instruction becomes a pure read.

The register bank holds three writable registers and one constant identifier:

| Address | Register | Minimum privilege |
|---|---|---|
| 0x340 | machine scratch | machine |
| 0x341 | machine exception PC | machine |
| 0x140 | supervisor scratch | supervisor |
| 0xF14 | hart identifier | machine (read-only space) |

The request is rejected as illegal, with no state change, in four cases:
- the address is unknown;
- the operation code is reserved;
- the current privilege is below the level encoded in address bits [9:8];
- a non-zero mask targets read-only space (address bits [11:10] = 2'b11).

The response is registered and appears one cycle after the request. The unit has no states: each request finishes in the clock edge that accepts it.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation code 2'b01 (swap) replaces the whole addressed register with `req_src`.
- R2: Operation code 2'b10 (bit-set) sets in the register every bit that is one in `req_src`, and leaves the other bits unchanged.
- R3: Operation code 2'b11 (bit-clear) clears in the register every bit that is one in `req_src`, and leaves the other bits unchanged.
- R4: Bit-set or bit-clear with `req_src_nz` low modifies no register. Such a request is legal even on read-only space.
- R5: An illegal request changes no register, and its response carries `rsp_rdata` of zero.
- R6: A legal request returns in `rsp_rdata` the value the register held before the write.
- R7: A request with a non-zero effective mask to an address whose bits [11:10] are 2'b11 is illegal.
- R8: A request is illegal when `cur_priv` (0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8].
- R9: An unknown address, or operation code 2'b00, is illegal.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R11: After reset the three writable registers read zero, and address 0xF14 reads the `HART_ID` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 01 swap, 10 bit-set, 11 bit-clear, 00 reserved |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field is not register zero |
| cur_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN | Old register value, zero when illegal |
| rsp_illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions assume that `req_op`, `req_addr` and `cur_priv` are held stable and defined whenever `req_valid` is high. They also assume `cur_priv` never takes the reserved value 2. The stimulus keeps within these limits: it changes inputs only on the falling edge, and it draws privilege only from {0, 1, 3}. Addresses are drawn from the four mapped registers plus two unmapped ones, so illegal cases occur throughout the random run.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    localparam int NUM_RW = 3;
    localparam logic [11:0] HARTID_ADDR = 12'hF14;

    function automatic logic [11:0] rw_addr(input int idx);
        case (idx)
            0:       return 12'h340;
            1:       return 12'h341;
            default: return 12'h140;
        endcase
    endfunction
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  src,
    input  logic             src_nz,
    output logic [XLEN-1:0]  wval,
    output logic [XLEN-1:0]  wmask,
    output logic             op_ok
);
    always_comb begin
        wval  = '0;
        wmask = '0;
        op_ok = 1'b1;
        unique case (op)
            OP_WRITE: begin
                wval  = src;
                wmask = '1;
            end
            OP_SET: begin
                wval  = '1;
                wmask = src_nz ? src : '0;
            end
            OP_CLEAR: begin
                wval  = '0;
                wmask = src_nz ? src : '0;
            end
            default: op_ok = 1'b0;
        endcase
    end

    // R4
    always_comb begin
        if ((op == OP_SET || op == OP_CLEAR) && !src_nz)
            zero_src_no_mask_chk: assert (wmask == '0);
    end
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check (
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    input  logic        mask_nz,
    input  logic        hit,
    input  logic        op_ok,
    output logic        illegal
);
    logic ro_space, priv_low;

    always_comb begin
        ro_space = (addr[11:10] == 2'b11);
        priv_low = (priv < addr[9:8]);
        illegal  = !op_ok || !hit || priv_low || (ro_space && mask_nz);
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter logic [31:0] HART_ID = 32'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     addr,
    input  logic            we,
    input  logic [XLEN-1:0] wval,
    input  logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] rdata,
    output logic            hit
);
    localparam logic [XLEN-1:0] HART_VAL = XLEN'(HART_ID);

    logic [XLEN-1:0]   regs [NUM_RW];
    logic [NUM_RW-1:0] sel;

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        assign sel[i] = (addr == rw_addr(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && sel[i])
                regs[i] <= (regs[i] & ~wmask) | (wval & wmask);
        end

        // R5
        unselected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel[i]) |=> $stable(regs[i]));
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (sel[i]) begin
                rdata = regs[i];
                hit   = 1'b1;
            end
        end
        if (addr == HARTID_ADDR) begin
            rdata = HART_VAL;
            hit   = 1'b1;
        end
    end

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter logic [31:0] HART_ID = 32'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [11:0]     req_addr,
    input  logic [XLEN-1:0] req_src,
    input  logic            req_src_nz,
    input  logic [1:0]      cur_priv,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_illegal
);
    logic [XLEN-1:0] wval, wmask, old_val;
    logic            op_ok, hit, illegal, we;

    csr_op_decode #(.XLEN(XLEN)) u_dec (
        .op     (csr_op_e'(req_op)),
        .src    (req_src),
        .src_nz (req_src_nz),
        .wval   (wval),
        .wmask  (wmask),
        .op_ok  (op_ok)
    );

    csr_bank #(.XLEN(XLEN), .HART_ID(HART_ID)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (req_addr),
        .we     (we),
        .wval   (wval),
        .wmask  (wmask),
        .rdata  (old_val),
        .hit    (hit)
    );

    csr_access_check u_chk (
        .addr    (req_addr),
        .priv    (cur_priv),
        .mask_nz (|wmask),
        .hit     (hit),
        .op_ok   (op_ok),
        .illegal (illegal)
    );

    assign we = req_valid && !illegal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_illegal <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_illegal <= req_valid && illegal;
            rsp_rdata   <= (req_valid && !illegal) ? old_val : '0;
        end
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid)));

    // R5
    illegal_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_valid && rsp_rdata == '0));

    // R7
    ro_write_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:10] == 2'b11 && wmask != '0) |=> rsp_illegal);

    // R8
    low_priv_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_priv < req_addr[9:8]) |=> rsp_illegal);
endmodule

// File: tb/csr_rmw_unit_tb_top.sv
module csr_rmw_unit_tb_top;
    localparam int          XLEN = 32;
    localparam logic [31:0] HID  = 32'h0000_0A5C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_op = 2'b00;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_src = '0;
    logic            req_src_nz = 1'b0;
    logic [1:0]      cur_priv = 2'd3;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_rdata;
    logic            rsp_illegal;

    int checks = 0;
    int fails  = 0;

    logic [XLEN-1:0] m_scr, m_epc, s_scr;

    always #5 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN), .HART_ID(HID)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_src(req_src), .req_src_nz(req_src_nz),
        .cur_priv(cur_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal)
    );

    task automatic check(input string req, input logic [XLEN:0] act, input logic [XLEN:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [11:0] a);
        return a == 12'h340 || a == 12'h341 || a == 12'h140 || a == 12'hF14;
    endfunction

    function automatic logic [XLEN-1:0] model_read(input logic [11:0] a);
        case (a)
            12'h340: return m_scr;
            12'h341: return m_epc;
            12'h140: return s_scr;
            12'hF14: return HID;
            default: return '0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] model_mask(input logic [1:0] op, input logic [XLEN-1:0] s, input logic nz);
        if (op == 2'b01) return '1;
        return nz ? s : '0;
    endfunction

    function automatic logic model_illegal(input logic [1:0] op, input logic [11:0] a,
                                           input logic [XLEN-1:0] s, input logic nz, input logic [1:0] p);
        return op == 2'b00 || !model_hit(a) || p < a[9:8] ||
               (a[11:10] == 2'b11 && model_mask(op, s, nz) != '0);
    endfunction

    task automatic issue(input string req, input logic [1:0] op, input logic [11:0] a,
                         input logic [XLEN-1:0] s, input logic nz, input logic [1:0] p);
        logic            ill;
        logic [XLEN-1:0] old, msk, val, nv;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_src = s;
        req_src_nz = nz; cur_priv = p;
        ill = model_illegal(op, a, s, nz, p);
        old = model_read(a);
        msk = model_mask(op, s, nz);
        val = (op == 2'b01) ? s : (op == 2'b10) ? '1 : '0;
        nv  = (old & ~msk) | (val & msk);
        if (!ill) begin
            case (a)
                12'h340: m_scr = nv;
                12'h341: m_epc = nv;
                12'h140: s_scr = nv;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R10 valid"}, {XLEN'(0), rsp_valid}, {XLEN'(0), 1'b1});
        check({req, " illegal"}, {XLEN'(0), rsp_illegal}, {XLEN'(0), ill});
        check({req, " R6 rdata"}, {1'b0, rsp_rdata}, {1'b0, ill ? '0 : old});
    endtask

    task automatic readback(input string req, input logic [11:0] a);
        issue({req, " readback"}, 2'b10, a, '0, 1'b0, 2'd3);
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_scr = '0; m_epc = '0; s_scr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 rsp_valid reset", {XLEN'(0), rsp_valid}, '0);
        readback("R11 mscratch", 12'h340);
        readback("R11 mepc", 12'h341);
        readback("R11 sscratch", 12'h140);
        readback("R11 hartid", 12'hF14);

        issue("R1 swap", 2'b01, 12'h340, 32'hDEAD_BEEF, 1'b1, 2'd3);
        readback("R1", 12'h340);
        issue("R2 set", 2'b10, 12'h340, 32'h0000_0F10, 1'b1, 2'd3);
        readback("R2", 12'h340);
        issue("R3 clear", 2'b11, 12'h340, 32'hFF00_0000, 1'b1, 2'd3);
        readback("R3", 12'h340);
        issue("R4 set zero src", 2'b10, 12'h340, 32'hFFFF_FFFF, 1'b0, 2'd3);
        issue("R4 clear zero src", 2'b11, 12'h340, 32'hFFFF_FFFF, 1'b0, 2'd3);
        issue("R4 ro read", 2'b11, 12'hF14, 32'h1234_5678, 1'b0, 2'd3);
        issue("R7 ro swap", 2'b01, 12'hF14, 32'h0, 1'b1, 2'd3);
        issue("R7 ro set", 2'b10, 12'hF14, 32'h1, 1'b1, 2'd3);
        issue("R8 user on sscratch", 2'b01, 12'h140, 32'h55, 1'b1, 2'd0);
        issue("R8 super on mepc", 2'b01, 12'h341, 32'h77, 1'b1, 2'd1);
        issue("R8 super on sscratch", 2'b01, 12'h140, 32'h99, 1'b1, 2'd1);
        issue("R9 unknown addr", 2'b01, 12'h7C0, 32'h1, 1'b1, 2'd3);
        issue("R9 reserved op", 2'b00, 12'h340, 32'h1, 1'b1, 2'd3);
        readback("R5 after illegal", 12'h341);
        readback("R5 after illegal", 12'h340);
        @(negedge clk);
        check("R10 idle", {XLEN'(0), rsp_valid}, '0);

        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op, p;
            logic [11:0] a;
            case ($urandom % 6)
                0: a = 12'h340; 1: a = 12'h341; 2: a = 12'h140;
                3: a = 12'hF14; 4: a = 12'h7C0; default: a = 12'h5A0;
            endcase
            case ($urandom % 3)
                0: p = 2'd0; 1: p = 2'd1; default: p = 2'd3;
            endcase
            op = 2'($urandom);
            issue("R1 R2 R3 R5 random", op, a, $urandom, 1'($urandom), p);
        end
        readback("R6 final", 12'h340);
        readback("R6 final", 12'h341);
        readback("R6 final", 12'h140);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule